// File: doc/BRIEF.md
# Multiplexed-Bus Slave Register Port

This block is the slave side of a host port on a shared 32-bit bus that carries both addresses and data. Three inputs from the host control it. `sel_n` (active low) opens an access. `asel_n` (active low) marks the address phase. `rd_wr` gives the direction. The block takes a register address from the bus, writes bus data into a 256-word by 32-bit register file, or drives register contents back to the host with an output enable that feeds an external tri-state buffer.

No access has a fixed length. A write stores the bus value from the last clock edge at which select was still low. Read data appears one edge after select is first seen low and stays until select is seen high. The host lengthens an access by holding select low longer.

The controller has five states:
- `ST_IDLE`: no access.
- `ST_NEED_ADDR`: select is low but no address has been taken yet.
- `ST_RD_WAIT`: the one-edge gap before read data is driven.
- `ST_RD_DRIVE`: read data is on the bus.
- `ST_WR_COLLECT`: bus data is being sampled for a write.

The transitions are:
- IDLE→RD_WAIT or IDLE→WR_COLLECT: an address is captured while select is low, and the direction decides which.
- IDLE→NEED_ADDR: select is low without an address.
- NEED_ADDR→RD_WAIT or NEED_ADDR→WR_COLLECT: a late address capture.
- NEED_ADDR→IDLE: select rises and nothing is written.
- RD_WAIT→RD_DRIVE: select is still low.
- RD_WAIT→IDLE: select has risen.
- RD_DRIVE→IDLE: select rises.
- WR_COLLECT→IDLE: select rises, and the register is written on that same edge.

Top module: `mbus_slave_port`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the controller returns to idle. `bus_oe` is 0 after that edge, and a write whose select rises on that edge is discarded.
- R2: The address is taken at a rising edge where `sel_n` and `asel_n` are both low. Only `bus_in[7:0]` forms the register index, and bits 31:8 have no effect.
- R3: `rd_wr` sampled at the address edge fixes the direction: 1 means read, 0 means write.
- R4: On a write, the register receives the `bus_in` value from the last rising edge at which `sel_n` was low. With a one-edge select pulse, this is the address-phase bus word.
- R5: On a read, `bus_oe` is 0 after the address edge and becomes 1 after the next edge if `sel_n` is still low there. `bus_out` then carries the addressed register.
- R6: While `bus_oe` stays 1, `bus_out` does not change. `bus_oe` returns to 0 after the first edge at which `sel_n` is sampled high.
- R7: `bus_oe` stays 0 for the whole of a write access.
- R8: If `sel_n` rises without any address capture in that access, no register is written.
- R9: A read whose select is low for only one edge never asserts `bus_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling is on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Slave select, active low |
| asel_n | input | 1 | Address phase marker, active low |
| rd_wr | input | 1 | Direction: 1 read, 0 write |
| bus_in | input | 32 | Value seen on the shared bus |
| bus_out | output | 32 | Read data to the bus driver |
| bus_oe | output | 1 | Enable for the bus tri-state driver |

## Verification
Writes are issued with select held low for one, two and five edges, with changing junk before the final data word. This separates last-edge capture from first-edge capture or a fixed cycle count. Reads are held for one, two and six edges after the address edge. These show the one-edge drive delay, the stability of the driven word, and release on the first high select. An address with nonzero upper bits is compared against its low-byte alias. A select pulse with no address phase checks that a stale captured address is not reused. Resets are placed in the middle of a write and in the middle of a read drive.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NEED_ADDR,
        ST_RD_WAIT,
        ST_RD_DRIVE,
        ST_WR_COLLECT
    } mbs_state_e;
endpackage

// File: rtl/mbs_regfile.sv
module mbs_regfile #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
    import mbs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              asel_n,
    input  logic              rd_wr,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]  idx_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              wr_en,
    output logic [DATA_W-1:0] rdata_q,
    output logic              oe
);
    mbs_state_e st_q, st_d;
    logic       take_addr;

    assign take_addr = !sel_n && !asel_n &&
                       (st_q == ST_IDLE || st_q == ST_NEED_ADDR);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (!sel_n) begin
                    if (!asel_n) st_d = rd_wr ? ST_RD_WAIT : ST_WR_COLLECT;
                    else         st_d = ST_NEED_ADDR;
                end
            end
            ST_NEED_ADDR: begin
                if (sel_n)        st_d = ST_IDLE;
                else if (!asel_n) st_d = rd_wr ? ST_RD_WAIT : ST_WR_COLLECT;
            end
            ST_RD_WAIT:    st_d = sel_n ? ST_IDLE : ST_RD_DRIVE;
            ST_RD_DRIVE:   if (sel_n) st_d = ST_IDLE;
            ST_WR_COLLECT: if (sel_n) st_d = ST_IDLE;
            default:       st_d = ST_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            idx_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            st_q <= st_d;
            if (take_addr) begin
                idx_q <= bus_in[IDX_W-1:0];
            end
            if (!sel_n && (take_addr || st_q == ST_WR_COLLECT)) begin
                wdata_q <= bus_in;
            end
            if (!sel_n && st_q == ST_RD_WAIT) begin
                rdata_q <= rd_data;
            end
        end
    end

    // outputs
    always_comb begin
        oe    = (st_q == ST_RD_DRIVE);
        wr_en = rst_n && sel_n && (st_q == ST_WR_COLLECT);
    end

    // R5: drive only after an edge with select low
    p_oe_after_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !$past(sel_n));

    // R6: read word held while driven
    p_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && $past(oe)) |-> $stable(rdata_q));

    // R6: release after select sampled high
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !oe);

    // R4: commit only on the first high edge after a low one
    p_write_point_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (sel_n && !$past(sel_n)));
endmodule

// File: rtl/mbus_slave_port.sv
module mbus_slave_port #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              asel_n,
    input  logic              rd_wr,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] rdata_q;
    logic              wr_en;

    mbs_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (sel_n),
        .asel_n  (asel_n),
        .rd_wr   (rd_wr),
        .bus_in  (bus_in),
        .rd_data (rd_data),
        .idx_q   (idx_q),
        .wdata_q (wdata_q),
        .wr_en   (wr_en),
        .rdata_q (rdata_q),
        .oe      (bus_oe)
    );

    mbs_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_regs (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (idx_q),
        .wr_data (wdata_q),
        .rd_idx  (idx_q),
        .rd_data (rd_data)
    );

    assign bus_out = rdata_q;
endmodule

// File: tb/mbus_slave_port_tb.sv
module mbus_slave_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        asel_n = 1'b1;
    logic        rd_wr = 1'b0;
    logic [31:0] bus_in = '0;
    logic [31:0] bus_out;
    logic        bus_oe;
    int          n_chk = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    mbus_slave_port u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .asel_n(asel_n),
        .rd_wr(rd_wr), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    // select low for 1+d edges; last low edge carries data (address word when d==0)
    task automatic do_write(input logic [31:0] addr, input int d, input logic [31:0] data);
        @(negedge clk);
        sel_n = 1'b0; asel_n = 1'b0; rd_wr = 1'b0; bus_in = addr;
        for (int i = 0; i < d; i++) begin
            @(negedge clk);
            chk("R7 oe during write", {31'b0, bus_oe}, 32'd0);
            asel_n = 1'b1;
            bus_in = (i == d - 1) ? data : (32'h5A5A_0000 + i);
        end
        @(negedge clk);
        chk("R7 oe during write", {31'b0, bus_oe}, 32'd0);
        sel_n = 1'b1; asel_n = 1'b1; bus_in = 32'hFFFF_FFFF;
        @(negedge clk);
        chk("R7 oe after write", {31'b0, bus_oe}, 32'd0);
    endtask

    // address edge plus hold edges with select low
    task automatic do_read(input logic [31:0] addr, input int hold, input logic [31:0] exp,
                           input string req);
        @(negedge clk);
        sel_n = 1'b0; asel_n = 1'b0; rd_wr = 1'b1; bus_in = addr;
        @(negedge clk);
        chk("R5 no drive after address edge", {31'b0, bus_oe}, 32'd0);
        asel_n = 1'b1; bus_in = 32'h0BAD_0000;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R5 oe driven", {31'b0, bus_oe}, 32'd1);
            chk(req, bus_out, exp);
            bus_in = bus_in + 32'd3;
        end
        sel_n = 1'b1;
        @(negedge clk);
        chk("R6 oe released", {31'b0, bus_oe}, 32'd0);
        rd_wr = 1'b0;
    endtask

    task automatic t_reset_state;
        chk("R1 reset oe", {31'b0, bus_oe}, 32'd0);
    endtask

    task automatic t_write_lengths;
        do_write(32'h0000_0010, 1, 32'hCAFE_0001);
        do_write(32'h0000_0011, 4, 32'hCAFE_0004);
        do_write(32'h0000_0033, 0, 32'h0);
        do_read(32'h0000_0010, 2, 32'hCAFE_0001, "R4 two-edge write");
        do_read(32'h0000_0011, 6, 32'hCAFE_0004, "R4 five-edge write last data");
        do_read(32'h0000_0033, 1, 32'h0000_0033, "R4 one-edge write takes address word");
    endtask

    task automatic t_upper_bits;
        do_write(32'hABCD_EF12, 1, 32'h1234_5678);
        do_read(32'h0000_0012, 2, 32'h1234_5678, "R2 upper bits ignored");
        do_write(32'h0000_0112, 1, 32'h8765_4321);
        do_read(32'hFFFF_FF12, 1, 32'h8765_4321, "R2 alias index");
    endtask

    task automatic t_direction;
        // read does not alter the register (R3): read twice
        do_read(32'h0000_0012, 1, 32'h8765_4321, "R3 read leaves data");
        do_read(32'h0000_0012, 1, 32'h8765_4321, "R3 read repeat");
    endtask

    task automatic t_short_read;
        @(negedge clk);
        sel_n = 1'b0; asel_n = 1'b0; rd_wr = 1'b1; bus_in = 32'h0000_0010;
        @(negedge clk);
        sel_n = 1'b1; asel_n = 1'b1;
        chk("R9 short read no drive", {31'b0, bus_oe}, 32'd0);
        @(negedge clk);
        chk("R9 short read no drive", {31'b0, bus_oe}, 32'd0);
        rd_wr = 1'b0;
    endtask

    task automatic t_no_addr;
        do_write(32'h0000_0044, 1, 32'h4444_4444);
        @(negedge clk);
        sel_n = 1'b0; asel_n = 1'b1; rd_wr = 1'b0; bus_in = 32'h9999_9999;
        @(negedge clk);
        bus_in = 32'h7777_7777;
        @(negedge clk);
        sel_n = 1'b1;
        @(negedge clk);
        do_read(32'h0000_0044, 1, 32'h4444_4444, "R8 no write without address");
    endtask

    task automatic t_reset_mid;
        do_write(32'h0000_0020, 1, 32'h2020_2020);
        @(negedge clk);
        sel_n = 1'b0; asel_n = 1'b0; rd_wr = 1'b0; bus_in = 32'h0000_0020;
        @(negedge clk);
        asel_n = 1'b1; bus_in = 32'h1111_1111;
        @(negedge clk);
        rst_n = 1'b0; sel_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 oe after reset", {31'b0, bus_oe}, 32'd0);
        do_read(32'h0000_0020, 1, 32'h2020_2020, "R1 write cancelled by reset");
        // reset during read drive
        @(negedge clk);
        sel_n = 1'b0; asel_n = 1'b0; rd_wr = 1'b1; bus_in = 32'h0000_0020;
        @(negedge clk);
        asel_n = 1'b1;
        @(negedge clk);
        chk("R5 oe before reset", {31'b0, bus_oe}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset drops oe", {31'b0, bus_oe}, 32'd0);
        rst_n = 1'b1; sel_n = 1'b1; rd_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_write_lengths();
        t_upper_bits();
        t_direction();
        t_short_read();
        t_no_addr();
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule